// File: doc/BRIEF.md
# Immediate Extender and Operand Select

This block sits in front of a processor ALU. It widens the 16-bit immediate field of an instruction to a full 32-bit word in one of three ways: sign extension for arithmetic immediates, zero extension for logical immediates, and upper-half placement for the load-upper-immediate operation. A 2-bit mode code picks the way.

The widened value is always visible on its own output. It is also offered to both ALU operand inputs. Each operand has its own 1-bit select that picks between the widened immediate and a register-file value: RS for operand A and RT for operand B. A select of 0 always picks the register. The block has no clock or state, so every output follows its inputs in the same cycle. The control unit, the ALU and the register file are outside this block.

Top module: `imm_operand_sel`

## Requirements
- R1: With mode code 2'b00, `ext_o[15:0]` equals the immediate and each bit of `ext_o[31:16]` equals `imm_i[15]`.
- R2: With mode code 2'b01, `ext_o[15:0]` equals the immediate and `ext_o[31:16]` is zero.
- R3: With mode code 2'b10, `ext_o[31:16]` equals the immediate and `ext_o[15:0]` is zero.
- R4: Mode code 2'b11 gives the same result as mode code 2'b00, which is sign extension.
- R5: When `sel_a_i` is 0, `opa_o` equals `rs_i`.
- R6: When `sel_a_i` is 1, `opa_o` equals `ext_o`.
- R7: When `sel_b_i` is 0, `opb_o` equals `rt_i`. When `sel_b_i` is 1, `opb_o` equals `ext_o`.
- R8: The two selects act independently. Both operands may carry the immediate at once, and `ext_o` does not depend on either select.
- R9: The block is purely combinational. An input change shows on the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imm_i | input | 16 | Instruction immediate field |
| ext_mode_i | input | 2 | Extend mode: 00 sign, 01 zero, 10 upper-half, 11 sign |
| rs_i | input | 32 | First register-file value |
| rt_i | input | 32 | Second register-file value |
| sel_a_i | input | 1 | Operand A source: 0 = rs_i, 1 = extended immediate |
| sel_b_i | input | 1 | Operand B source: 0 = rt_i, 1 = extended immediate |
| ext_o | output | 32 | Extended immediate |
| opa_o | output | 32 | ALU operand A |
| opb_o | output | 32 | ALU operand B |

## Verification
The cases most likely to hide a defect are the immediates at the sign boundary, 16'h7FFF and 16'h8000, and the unused mode code 11. A wrong fill source or a missing default in the mode decode only shows up under these inputs. The stimulus therefore sweeps a fixed set of boundary immediates through all four mode codes and all four select pairs. Randomised vectors follow, and register values that differ from the immediate in every bit, so that a wrong mux leg cannot match by chance. Each vector is checked twice: first shortly after the input change with no clock edge in between, then again on the next clock.

// File: rtl/imm_sel_pkg.sv
package imm_sel_pkg;
  typedef enum logic [1:0] {
    EXT_SIGN  = 2'b00,
    EXT_ZERO  = 2'b01,
    EXT_UPPER = 2'b10,
    EXT_RSVD  = 2'b11
  } ext_mode_e;
endpackage

// File: rtl/imm_extender.sv
module imm_extender
  import imm_sel_pkg::*;
#(
  parameter int IMM_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [1:0]        mode_i,
  output logic [DATA_W-1:0] ext_o
);
  localparam int PAD_W = DATA_W - IMM_W;

  ext_mode_e                mode;
  logic [DATA_W-1:0]        sign_ext, zero_ext, upper_ext;

  assign mode      = ext_mode_e'(mode_i);
  assign sign_ext  = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
  assign zero_ext  = {{PAD_W{1'b0}}, imm_i};
  assign upper_ext = {imm_i, {PAD_W{1'b0}}};

  always_comb begin
    unique case (mode)
      EXT_ZERO:  ext_o = zero_ext;
      EXT_UPPER: ext_o = upper_ext;
      default:   ext_o = sign_ext; // reserved code falls back to sign
    endcase
  end
endmodule

// File: rtl/operand_mux.sv
module operand_mux #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] reg_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              sel_imm_i,
  output logic [DATA_W-1:0] op_o
);
  assign op_o = sel_imm_i ? imm_i : reg_i;
endmodule

// File: rtl/imm_operand_sel.sv
module imm_operand_sel #(
  parameter int IMM_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [1:0]        ext_mode_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] rt_i,
  input  logic              sel_a_i,
  input  logic              sel_b_i,
  output logic [DATA_W-1:0] ext_o,
  output logic [DATA_W-1:0] opa_o,
  output logic [DATA_W-1:0] opb_o
);
  localparam int N_OPS = 2;

  logic [DATA_W-1:0] ext_val;
  logic [DATA_W-1:0] reg_src [N_OPS];
  logic [DATA_W-1:0] op_res  [N_OPS];
  logic [N_OPS-1:0]  sel_vec;

  imm_extender #(.IMM_W(IMM_W), .DATA_W(DATA_W)) i_ext (
    .imm_i  (imm_i),
    .mode_i (ext_mode_i),
    .ext_o  (ext_val)
  );

  assign reg_src[0] = rs_i;
  assign reg_src[1] = rt_i;
  assign sel_vec    = {sel_b_i, sel_a_i};

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    operand_mux #(.DATA_W(DATA_W)) i_mux (
      .reg_i     (reg_src[g]),
      .imm_i     (ext_val),
      .sel_imm_i (sel_vec[g]),
      .op_o      (op_res[g])
    );
  end

  assign ext_o = ext_val;
  assign opa_o = op_res[0];
  assign opb_o = op_res[1];
endmodule

// File: rtl/imm_operand_sel_chk.sv
module imm_operand_sel_chk #(
  parameter int IMM_W  = 16,
  parameter int DATA_W = 32
) (
  input logic [IMM_W-1:0]  imm_i,
  input logic [1:0]        ext_mode_i,
  input logic [DATA_W-1:0] rs_i,
  input logic [DATA_W-1:0] rt_i,
  input logic              sel_a_i,
  input logic              sel_b_i,
  input logic [DATA_W-1:0] ext_o,
  input logic [DATA_W-1:0] opa_o,
  input logic [DATA_W-1:0] opb_o
);
  localparam int PAD_W = DATA_W - IMM_W;

  always_comb begin
    if (ext_mode_i == 2'b00 || ext_mode_i == 2'b11) begin
      p_sign_fill_r1: assert (ext_o == {{PAD_W{imm_i[IMM_W-1]}}, imm_i});
    end
    if (ext_mode_i == 2'b01) begin
      p_zero_fill_r2: assert (ext_o[DATA_W-1:IMM_W] == '0 && ext_o[IMM_W-1:0] == imm_i);
    end
    if (ext_mode_i == 2'b10) begin
      p_upper_align_r3: assert (ext_o[DATA_W-1:PAD_W] == imm_i && ext_o[PAD_W-1:0] == '0);
    end
    if (!sel_a_i) begin
      p_opa_reg_r5: assert (opa_o == rs_i);
    end
    if (sel_a_i) begin
      p_opa_imm_r6: assert (opa_o == ext_o);
    end
    if (sel_b_i) begin
      p_opb_imm_r7: assert (opb_o == ext_o);
    end else begin
      p_opb_reg_r7: assert (opb_o == rt_i);
    end
    if (sel_a_i && sel_b_i) begin
      p_both_imm_r8: assert (opa_o == opb_o);
    end
  end
endmodule

bind imm_operand_sel imm_operand_sel_chk #(.IMM_W(IMM_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_imm_operand_sel.sv
module test_imm_operand_sel;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] imm_i = '0;
  logic [1:0]  ext_mode_i = '0;
  logic [31:0] rs_i = '0, rt_i = '0;
  logic        sel_a_i = 1'b0, sel_b_i = 1'b0;
  logic [31:0] ext_o, opa_o, opb_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  imm_operand_sel i_imm_operand_sel (.*);

  function automatic logic [31:0] model_ext(input logic [15:0] imm, input logic [1:0] mode);
    longint v;
    v = imm;
    case (mode)
      2'd1: return v[31:0];
      2'd2: return 32'(v * 65536);
      default: begin
        if (v >= 32768) v = v + 64'h0000_0000_FFFF_0000;
        return v[31:0];
      end
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic verify();
    logic [31:0] e;
    string mtag;
    e = model_ext(imm_i, ext_mode_i);
    case (ext_mode_i)
      2'd0: mtag = "R1";
      2'd1: mtag = "R2";
      2'd2: mtag = "R3";
      default: mtag = "R4";
    endcase
    check(mtag, ext_o, e);
    check(sel_a_i ? "R6" : "R5", opa_o, sel_a_i ? e : rs_i);
    check("R7", opb_o, sel_b_i ? e : rt_i);
  endtask

  // apply between edges, check after settling (R9: no edge) and again at next clock
  task automatic apply(input logic [15:0] imm, input logic [1:0] mode,
                       input logic [31:0] rs, input logic [31:0] rt,
                       input logic sa, input logic sb);
    @(negedge clk);
    imm_i = imm; ext_mode_i = mode; rs_i = rs; rt_i = rt;
    sel_a_i = sa; sel_b_i = sb;
    #2;
    verify();  // R9 combinational response
    @(posedge clk); #3;
    verify();
  endtask

  initial begin
    logic [15:0] edges [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hA5C3};
    #1;
    check("R9", ext_o, 32'h0);  // reset-state inputs all zero
    check("R5", opa_o, 32'h0);
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 6; i++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 4; s++)
          apply(edges[i], 2'(m), ~{edges[i], edges[i]}, 32'h5A5A_1234 ^ {16'h0, edges[i]},
                s[0], s[1]);
    // R4: reserved code matches sign mode
    apply(16'h8001, 2'd3, 32'h0, 32'h0, 1'b1, 1'b1);
    check("R4", ext_o, 32'hFFFF_8001);
    // R8: selects independent; ext_o ignores selects
    apply(16'h1234, 2'd2, 32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b1, 1'b0);
    check("R8", ext_o, 32'h1234_0000);
    check("R8", opb_o, 32'hCAFE_F00D);
    apply(16'h1234, 2'd2, 32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b0, 1'b1);
    check("R8", ext_o, 32'h1234_0000);
    check("R8", opa_o, 32'hDEAD_BEEF);
    for (int k = 0; k < 400; k++)
      apply(16'($urandom), 2'($urandom), $urandom, $urandom, 1'($urandom), 1'($urandom));
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule